// File: doc/BRIEF.md
# Network Control Command Decoder

This block sits behind a packet receiver that has already removed the IP and UDP headers. It takes the remaining UDP payload as a stream of 32-bit words on a valid/ready interface, with start-of-packet and end-of-packet flags. The top byte of the first word selects a command, and the decoder carries it out. A memory-write command streams its data words to consecutive SRAM addresses. A memory-read command issues one SRAM read and returns the word on a reply stream. The start and halt commands each give a one-cycle pulse to the processor controller. The sequence number of the most recent write command is kept on an output, so that the host can detect lost packets.

There are three streams, and all use valid/ready. The command stream (`cmd_*`) is accepted when `cmd_valid && cmd_ready`. The memory request stream (`mem_req_*`) is consumed when `mem_req_valid && mem_req_ready`. The reply stream (`rsp_*`) holds `rsp_valid` and `rsp_data` steady until `rsp_ready`. Back-pressure passes straight through: a write data word is accepted only in the cycle its memory request is taken. A read address word waits both for the memory and for a free reply slot. Read data returns on `mem_rd_valid`/`mem_rd_data` one or more cycles after the read request, and only for a read the decoder has issued.

Top module: `netcmd_decoder`

## Requirements
- R1: After reset, `cmd_ready` is 1, `mem_req_valid`, `rsp_valid`, `cpu_start` and `cpu_halt` are 0, and `last_seq` is 0.
- R2: The opcode is bits 31:24 of the first word of a packet. Opcode 0x50 gives exactly one `cpu_start` cycle and opcode 0x54 gives exactly one `cpu_halt` cycle, in the cycle after that word is accepted. Any further words of the packet are discarded.
- R3: Opcode 0x64 is a write. Word 2 is a sequence number, word 3 is the base address, and the words after that are data. Data word i is requested with `mem_req_we`=1 at address base+4*i, with the payload word unchanged (first byte in bits 31:24).
- R4: The write byte count is bits 15:0 of the opcode word. At most ceil(count/4) data words are written. Data words beyond that, up to end-of-packet, are accepted and produce no request.
- R5: Every write word has `mem_req_strb`=4'b1111 except a final partial word. That word has 4'b1000, 4'b1100 or 4'b1110 when 1, 2 or 3 bytes remain (strobe bit 3 covers bits 31:24).
- R6: An end-of-packet flag ends the write at once. No request is made for words that were not received, including when the packet ends inside the header.
- R7: `last_seq` takes the sequence word of a write packet when that word is accepted, and keeps its value at all other times.
- R8: Opcode 0x60 is a read. The next word is the address. It produces one request with `mem_req_we`=0 and strobe 4'b1111, and the returned word appears on `rsp_data` with `rsp_valid`.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` stay unchanged, and the address word of a later read is not accepted.
- R10: A first word with any other opcode makes the decoder discard the rest of the packet. It then issues no request, no pulse and no reply, and leaves `last_seq` unchanged.
- R11: While no packet is open, a word without start-of-packet is accepted and discarded with no effect.
- R12: When `mem_req_ready` is low, write data words are held off. Every data word is written exactly once, in order.
- R13: A write with byte count 0 issues no request, and its data words are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Payload word valid |
| cmd_ready | output | 1 | Payload word accepted when high with valid |
| cmd_data | input | 32 | Payload word |
| cmd_sop | input | 1 | First word of a packet |
| cmd_eop | input | 1 | Last word of a packet |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_req_strb | output | 4 | Byte enables, bit 3 for bits 31:24 |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Read data |
| rsp_valid | output | 1 | Reply word valid |
| rsp_ready | input | 1 | Reply consumer ready |
| rsp_data | output | 32 | Reply word |
| cpu_start | output | 1 | One-cycle start pulse |
| cpu_halt | output | 1 | One-cycle halt pulse |
| last_seq | output | 32 | Most recent write sequence number |

## Verification
An FSM stuck in the wrong state shows up within a packet. Either later words bring no memory request or pulse, or `cmd_ready` stays low and the stream stops at the next word. A wrong byte counter or address register shows on the first write after it: an extra or missing request, a wrong strobe on the final word, or an address that does not step by four. Because of this, every table entry compares each logged request and the request count once the packet has drained. A reply slot that loses or overwrites data appears on `rsp_data` as soon as a reply is held under back-pressure, which is why one test stalls two reads behind `rsp_ready`.

// File: rtl/netcmd_pkg.sv
package netcmd_pkg;

  localparam logic [7:0] OP_WRITE = 8'h64;
  localparam logic [7:0] OP_READ  = 8'h60;
  localparam logic [7:0] OP_START = 8'h50;
  localparam logic [7:0] OP_HALT  = 8'h54;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEQ,
    ST_BASE,
    ST_DATA,
    ST_RADDR,
    ST_RWAIT,
    ST_DROP
  } dec_state_t;

  // Byte enables for a final word holding r (1..3) bytes; r==0 means full word.
  function automatic logic [3:0] tail_strb(input logic [1:0] r);
    case (r)
      2'd1:    tail_strb = 4'b1000;
      2'd2:    tail_strb = 4'b1100;
      2'd3:    tail_strb = 4'b1110;
      default: tail_strb = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/netcmd_rsp_hold.sv
module netcmd_rsp_hold #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  output logic          full,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data
);

  logic [DW-1:0] data_q;
  logic          full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (load) begin
      full_q <= 1'b1;
      data_q <= load_data;
    end else if (full_q && rsp_ready) begin
      full_q <= 1'b0;
    end
  end

  assign full      = full_q;
  assign rsp_valid = full_q;
  assign rsp_data  = data_q;

  // R9
  rsp_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R9
  rsp_no_clobber_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !full_q);

endmodule

// File: rtl/netcmd_ctrl.sv
module netcmd_ctrl
  import netcmd_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_data,
  input  logic          in_sop,
  input  logic          in_eop,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_we,
  output logic [AW-1:0] req_addr,
  output logic [31:0]   req_wdata,
  output logic [3:0]    req_strb,
  input  logic          rd_valid,
  input  logic          rsp_full,
  output logic          rsp_load,
  output logic          start_pulse,
  output logic          halt_pulse,
  output logic [31:0]   last_seq
);

  localparam logic [LW-1:0] WORD_BYTES = LW'(4);
  localparam logic [AW-1:0] ADDR_STEP  = AW'(4);

  dec_state_t    st;
  logic [LW-1:0] bytes_left;
  logic [AW-1:0] wr_addr;
  logic          tail_drop;
  logic          beat;
  logic          have_bytes;
  logic [7:0]    opcode;

  assign opcode     = in_data[31:24];
  assign have_bytes = (bytes_left != '0);
  assign beat       = in_valid && in_ready;

  always_comb begin
    in_ready  = 1'b1;
    req_valid = 1'b0;
    case (st)
      ST_DATA: begin
        if (have_bytes) begin
          in_ready  = req_ready;
          req_valid = in_valid;
        end
      end
      ST_RADDR: begin
        in_ready  = req_ready && !rsp_full;
        req_valid = in_valid && !rsp_full;
      end
      ST_RWAIT: in_ready = 1'b0;
      default:  in_ready = 1'b1;
    endcase
  end

  assign req_we    = (st == ST_DATA);
  assign req_addr  = (st == ST_DATA) ? wr_addr : in_data[AW-1:0];
  assign req_wdata = in_data;
  assign req_strb  = ((st == ST_DATA) && (bytes_left < WORD_BYTES))
                     ? tail_strb(bytes_left[1:0]) : 4'b1111;
  assign rsp_load  = (st == ST_RWAIT) && rd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      bytes_left  <= '0;
      wr_addr     <= '0;
      tail_drop   <= 1'b0;
      start_pulse <= 1'b0;
      halt_pulse  <= 1'b0;
      last_seq    <= '0;
    end else begin
      start_pulse <= 1'b0;
      halt_pulse  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (beat && in_sop) begin
            case (opcode)
              OP_WRITE: begin
                bytes_left <= in_data[LW-1:0];
                st         <= in_eop ? ST_IDLE : ST_SEQ;
              end
              OP_READ:  st <= in_eop ? ST_IDLE : ST_RADDR;
              OP_START: begin
                start_pulse <= 1'b1;
                st          <= in_eop ? ST_IDLE : ST_DROP;
              end
              OP_HALT: begin
                halt_pulse <= 1'b1;
                st         <= in_eop ? ST_IDLE : ST_DROP;
              end
              default:  st <= in_eop ? ST_IDLE : ST_DROP;
            endcase
          end
        end
        ST_SEQ: begin
          if (beat) begin
            last_seq <= in_data;
            st       <= in_eop ? ST_IDLE : ST_BASE;
          end
        end
        ST_BASE: begin
          if (beat) begin
            wr_addr <= in_data[AW-1:0];
            st      <= in_eop ? ST_IDLE : ST_DATA;
          end
        end
        ST_DATA: begin
          if (beat) begin
            if (have_bytes) begin
              wr_addr    <= wr_addr + ADDR_STEP;
              bytes_left <= (bytes_left >= WORD_BYTES) ? bytes_left - WORD_BYTES : '0;
            end
            if (in_eop) st <= ST_IDLE;
          end
        end
        ST_RADDR: begin
          if (beat) begin
            tail_drop <= !in_eop;
            st        <= ST_RWAIT;
          end
        end
        ST_RWAIT: begin
          if (rd_valid) st <= tail_drop ? ST_DROP : ST_IDLE;
        end
        ST_DROP: begin
          if (beat && in_eop) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  wr_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_DATA) && $past(st == ST_DATA) && $past(req_valid && req_ready && req_we))
    |-> (req_addr == $past(req_addr) + ADDR_STEP));

  // R7
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(last_seq) |-> $past((st == ST_SEQ) && beat));

  // R2
  pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse || halt_pulse) |-> $past((st == ST_IDLE) && beat && in_sop));

  // R8
  rd_only_when_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (st == ST_RWAIT));

endmodule

// File: rtl/netcmd_decoder.sv
module netcmd_decoder #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [31:0]       cmd_data,
  input  logic              cmd_sop,
  input  logic              cmd_eop,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  output logic [3:0]        mem_req_strb,
  input  logic              mem_rd_valid,
  input  logic [31:0]       mem_rd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  output logic              cpu_start,
  output logic              cpu_halt,
  output logic [31:0]       last_seq
);

  logic rsp_full;
  logic rsp_load;

  netcmd_ctrl #(.AW(ADDR_W), .LW(LEN_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (cmd_valid),
    .in_ready    (cmd_ready),
    .in_data     (cmd_data),
    .in_sop      (cmd_sop),
    .in_eop      (cmd_eop),
    .req_valid   (mem_req_valid),
    .req_ready   (mem_req_ready),
    .req_we      (mem_req_we),
    .req_addr    (mem_req_addr),
    .req_wdata   (mem_req_wdata),
    .req_strb    (mem_req_strb),
    .rd_valid    (mem_rd_valid),
    .rsp_full    (rsp_full),
    .rsp_load    (rsp_load),
    .start_pulse (cpu_start),
    .halt_pulse  (cpu_halt),
    .last_seq    (last_seq)
  );

  netcmd_rsp_hold #(.DW(32)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rsp_load),
    .load_data (mem_rd_data),
    .full      (rsp_full),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data)
  );

endmodule

// File: tb/netcmd_decoder_bench.sv
`timescale 1ns/1ps
module netcmd_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_data = '0;
  logic        cmd_sop = 1'b0;
  logic        cmd_eop = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic        mem_req_we;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic [3:0]  mem_req_strb;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        cpu_start;
  logic        cpu_halt;
  logic [31:0] last_seq;

  always #2.5 clk = ~clk;

  netcmd_decoder u_netcmd_decoder (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_sop(cmd_sop), .cmd_eop(cmd_eop),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_strb(mem_req_strb),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .cpu_start(cpu_start), .cpu_halt(cpu_halt), .last_seq(last_seq)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Memory model and request log
  logic [31:0] wl_addr [64];
  logic [31:0] wl_data [64];
  logic [3:0]  wl_strb [64];
  int wl_n = 0;
  int rd_n = 0;
  int rsp_n = 0;
  int start_n = 0;
  int halt_n = 0;
  bit stall_mode = 1'b0;
  int cyc = 0;

  function automatic logic [31:0] rd_fn(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (cpu_start) start_n = start_n + 1;
    if (cpu_halt)  halt_n  = halt_n + 1;
    if (rsp_valid && rsp_ready) rsp_n = rsp_n + 1;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        if (wl_n < 64) begin
          wl_addr[wl_n] = mem_req_addr;
          wl_data[wl_n] = mem_req_wdata;
          wl_strb[wl_n] = mem_req_strb;
        end
        wl_n = wl_n + 1;
      end else begin
        rd_n = rd_n + 1;
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= rd_fn(mem_req_addr);
      end
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= stall_mode ? ((cyc % 3) != 0) : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic beat(input logic [31:0] d, input bit s, input bit e);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = d; cmd_sop = s; cmd_eop = e;
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_sop = 1'b0; cmd_eop = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rsp(output bit got);
    got = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rsp_valid) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  // Write vectors: byte count, base, sequence, data words sent, expected writes, last strobe
  localparam int NV = 6;
  localparam logic [15:0] V_LEN  [NV] = '{16'd8, 16'd6, 16'd5, 16'd16, 16'd3, 16'd0};
  localparam logic [31:0] V_BASE [NV] = '{32'h100, 32'h2000, 32'h40, 32'h80, 32'hFFC, 32'h10};
  localparam logic [31:0] V_SEQ  [NV] = '{32'h1, 32'h2, 32'h7, 32'h99, 32'hABCD, 32'h5};
  localparam int          V_BEAT [NV] = '{2, 2, 4, 2, 1, 2};
  localparam int          V_NWR  [NV] = '{2, 2, 2, 2, 1, 0};
  localparam logic [3:0]  V_LSTB [NV] = '{4'hF, 4'hC, 4'h8, 4'hF, 4'hE, 4'hF};
  localparam string       V_REQ  [NV] = '{"R3", "R5", "R4", "R6", "R5", "R13"};

  task automatic run_write(input logic [15:0] len, input logic [31:0] base,
                           input logic [31:0] seq, input int nbeat, input int v,
                           input int nwr, input logic [3:0] lstb, input string req);
    int w0;
    w0 = wl_n;
    beat({8'h64, 8'h00, len}, 1'b1, 1'b0);
    beat(seq, 1'b0, 1'b0);
    beat(base, 1'b0, nbeat == 0);
    for (int i = 0; i < nbeat; i++)
      beat(32'hC0DE_0000 | (v << 8) | i, 1'b0, i == nbeat - 1);
    idle(4);
    chk(wl_n - w0 == nwr, req, "write count", wl_n - w0, nwr);
    for (int i = 0; i < nwr; i++) begin
      chk(wl_addr[w0+i] == base + 4*i, "R3", "write addr", wl_addr[w0+i], base + 4*i);
      chk(wl_data[w0+i] == (32'hC0DE_0000 | (v << 8) | i), "R3", "write data",
          wl_data[w0+i], 32'hC0DE_0000 | (v << 8) | i);
      chk(wl_strb[w0+i] == ((i == nwr - 1) ? lstb : 4'hF), "R5", "strobe",
          wl_strb[w0+i], (i == nwr - 1) ? lstb : 4'hF);
    end
    chk(last_seq == seq, "R7", "last_seq", last_seq, seq);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int s0, h0, r0, w0, q0;
    bit got;
    logic [31:0] seq0;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    chk(cmd_ready == 1'b1, "R1", "cmd_ready", cmd_ready, 1);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", mem_req_valid, 0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
    chk(!cpu_start && !cpu_halt, "R1", "pulses", {cpu_start, cpu_halt}, 0);
    chk(last_seq == 32'h0, "R1", "last_seq", last_seq, 0);

    // Table walk: R3 R4 R5 R6 R7 R13
    for (int v = 0; v < NV; v++)
      run_write(V_LEN[v], V_BASE[v], V_SEQ[v], V_BEAT[v], v, V_NWR[v], V_LSTB[v], V_REQ[v]);

    // R6: packet ends after the sequence word
    w0 = wl_n;
    beat(32'h6400_0010, 1'b1, 1'b0);
    beat(32'h0000_0777, 1'b0, 1'b1);
    idle(4);
    chk(wl_n == w0, "R6", "writes after header eop", wl_n - w0, 0);
    chk(last_seq == 32'h777, "R7", "last_seq short packet", last_seq, 32'h777);

    // R2 start and halt
    s0 = start_n; h0 = halt_n;
    beat(32'h5000_0000, 1'b1, 1'b1);
    idle(3);
    chk(start_n - s0 == 1, "R2", "start pulses", start_n - s0, 1);
    chk(halt_n == h0, "R2", "halt on start", halt_n - h0, 0);
    beat(32'h5400_0000, 1'b1, 1'b0);
    beat(32'h6400_0004, 1'b0, 1'b1);
    idle(3);
    chk(halt_n - h0 == 1, "R2", "halt pulses", halt_n - h0, 1);
    chk(start_n - s0 == 1, "R2", "start on halt", start_n - s0, 1);

    // R8 read
    r0 = rd_n; q0 = rsp_n;
    beat(32'h6000_0000, 1'b1, 1'b0);
    beat(32'h0000_0300, 1'b0, 1'b1);
    idle(0);
    wait_rsp(got);
    chk(got, "R8", "reply seen", got, 1);
    chk(rsp_data == rd_fn(32'h300), "R8", "reply data", rsp_data, rd_fn(32'h300));
    idle(2);
    chk(rd_n - r0 == 1, "R8", "read requests", rd_n - r0, 1);
    chk(rsp_n - q0 == 1, "R8", "replies", rsp_n - q0, 1);

    // R9 reply back-pressure
    rsp_ready = 1'b0;
    beat(32'h6000_0000, 1'b1, 1'b0);
    beat(32'h0000_0A00, 1'b0, 1'b1);
    idle(0);
    wait_rsp(got);
    repeat (4) @(negedge clk);
    chk(rsp_valid && rsp_data == rd_fn(32'hA00), "R9", "held reply", rsp_data, rd_fn(32'hA00));
    beat(32'h6000_0000, 1'b1, 1'b0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = 32'h0000_0B00; cmd_sop = 1'b0; cmd_eop = 1'b1;
    #1;
    chk(cmd_ready == 1'b0, "R9", "addr stalled", cmd_ready, 0);
    repeat (3) @(negedge clk);
    #1;
    chk(rsp_data == rd_fn(32'hA00), "R9", "reply stable", rsp_data, rd_fn(32'hA00));
    chk(cmd_ready == 1'b0, "R9", "addr still stalled", cmd_ready, 0);
    rsp_ready = 1'b1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    idle(0);
    wait_rsp(got);
    chk(got && rsp_data == rd_fn(32'hB00), "R9", "second reply", rsp_data, rd_fn(32'hB00));
    idle(2);

    // R10 unknown opcode
    s0 = start_n; h0 = halt_n; r0 = rd_n; q0 = rsp_n; w0 = wl_n; seq0 = last_seq;
    beat(32'h7700_0008, 1'b1, 1'b0);
    beat(32'h6400_0008, 1'b0, 1'b0);
    beat(32'h5000_0000, 1'b0, 1'b0);
    beat(32'h6000_0000, 1'b0, 1'b1);
    idle(4);
    chk(wl_n == w0 && rd_n == r0, "R10", "requests", (wl_n - w0) + (rd_n - r0), 0);
    chk(start_n == s0 && halt_n == h0, "R10", "pulses", (start_n - s0) + (halt_n - h0), 0);
    chk(rsp_n == q0 && last_seq == seq0, "R10", "reply/seq", last_seq, seq0);
    beat(32'h5000_0000, 1'b1, 1'b1);
    idle(3);
    chk(start_n - s0 == 1, "R10", "start after drop", start_n - s0, 1);

    // R11 words without start-of-packet while idle
    s0 = start_n; w0 = wl_n;
    beat(32'h5000_0000, 1'b0, 1'b1);
    beat(32'h6400_0004, 1'b0, 1'b0);
    beat(32'h0000_0001, 1'b0, 1'b0);
    beat(32'h0000_0100, 1'b0, 1'b0);
    beat(32'h1111_1111, 1'b0, 1'b1);
    idle(4);
    chk(start_n == s0, "R11", "no start", start_n - s0, 0);
    chk(wl_n == w0, "R11", "no write", wl_n - w0, 0);

    // R12 memory back-pressure
    stall_mode = 1'b1;
    run_write(16'd16, 32'h3000, 32'h4242, 4, 9, 4, 4'hF, "R12");
    stall_mode = 1'b0;
    idle(2);

    finish_run();
  end

endmodule